// File: doc/BRIEF.md
# Charge Pump Ratio Mode Controller

This block is the digital control core of a three-ratio switched-capacitor converter. It receives comparator results that are already digital. One pair of flags describes how the input compares with twice the target. A second pair describes how the input compares with the target itself. Each pair has a rising-threshold flag and a falling-threshold flag, which gives the comparator its hysteresis. The block also receives a flag for output below target, trip and release flags for output overvoltage and for overtemperature, and an undervoltage lockout flag. From these it selects one of three conversion ratios: step-down by two, pass-through, or step-up by two. It also decodes two select pins into a one-hot regulation target or shutdown.

Regulation works in bursts, not by fixed-frequency modulation. On a tick of the free-running oscillator, a transfer cycle starts only if the output is below target. In the switched ratios a cycle is phase A, one dead tick, phase B, one dead tick, then one idle tick. In pass-through, phase A stays on for all but two ticks of the oscillator period. The overvoltage and overtemperature guards each latch on their trip flag and release only on their own release flag. Shutdown, a guard trip and lockout each end an active cycle at the next clock.

Top module: `cp_ratio_ctrl`

## Requirements
- R1: `sel_i` is decoded into `target_o` one clock after it changes. 00 gives 000 with `pulldown_o`=1. 01 gives 001 (adjustable). 10 gives 010 (fixed 5 V). 11 gives 100 (fixed 3.3 V). `pulldown_o` is 1 exactly when `target_o` is 000.
- R2: `ratio_o` takes the code 01 for step-down by two, 10 for pass-through and 11 for step-up by two. 00 never appears. The wanted ratio is 01 when the input is above twice the target, otherwise 10 when the input is above the target, otherwise 11. The ratio changes only on a clock where `osc_tick_i` is high.
- R3: Hysteresis works as follows. While the ratio is 01, the falling flag `dbl_fall_i` is used for the twice-target comparison; in any other ratio `dbl_rise_i` is used. While the ratio is 11, the rising flag `tgt_rise_i` is used for the target comparison; in any other ratio `tgt_fall_i` is used.
- R4: After a ratio change, the ratio holds for at least DWELL_TICKS ticks (default 2). With the default it can change again on the third tick at the earliest. A change happens only while no transfer cycle is in progress. Reset leaves the ratio at 10.
- R5: A transfer cycle starts only on a tick where `out_low_i` is 1. With `out_low_i` at 0 and the cycle finished, both phase outputs stay 0.
- R6: With ratio 01 or 11 and PHASE_TICKS=2, continuous demand gives this pattern on the outputs after ticks 1 to 8: `phase_a_o`=1,1,0,0,0,0,0,1 and `phase_b_o`=0,0,0,1,1,0,0,0.
- R7: With ratio 10 and PERIOD_TICKS=8, continuous demand gives `phase_a_o`=1 for six ticks and 0 for two, repeating. `phase_b_o` stays 0.
- R8: `phase_a_o` and `phase_b_o` are never 1 together. Either one rises only if the other was 0 on the previous clock.
- R9: `ovp_trip_i` forces both phase outputs to 0 on the next clock. Transfer stays blocked after the trip flag drops, until `ovp_release_i` has been seen.
- R10: `ot_trip_i` forces both phase outputs to 0 on the next clock. Transfer stays blocked after the trip flag drops, until `ot_release_i` has been seen.
- R11: Shutdown (`sel_i`=00) or `uvlo_i`=1 forces both phase outputs to 0 on the next clock and keeps them there. Lockout does not latch, so transfer resumes on the first tick after it clears.
- R12: During and right after reset, both phase outputs are 0, `ratio_o` is 10, and `target_o`/`pulldown_o` follow R1 for `sel_i`=00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 2 | Target select pins; bit 1 picks the fixed-target group |
| osc_tick_i | input | 1 | One-clock oscillator tick |
| dbl_rise_i | input | 1 | Input above twice target, upper trip point |
| dbl_fall_i | input | 1 | Input above twice target, lower trip point |
| tgt_rise_i | input | 1 | Input above target, upper trip point |
| tgt_fall_i | input | 1 | Input above target, lower trip point |
| out_low_i | input | 1 | Output below regulation target |
| ovp_trip_i | input | 1 | Output overvoltage trip |
| ovp_release_i | input | 1 | Output has fallen below the overvoltage release point |
| ot_trip_i | input | 1 | Overtemperature trip |
| ot_release_i | input | 1 | Temperature below the release point |
| uvlo_i | input | 1 | Input undervoltage lockout |
| target_o | output | 3 | One-hot target: bit0 adjustable, bit1 5 V, bit2 3.3 V |
| ratio_o | output | 2 | Selected conversion ratio code |
| phase_a_o | output | 1 | Phase A switch enable |
| phase_b_o | output | 1 | Phase B switch enable |
| pulldown_o | output | 1 | Output discharge enable in shutdown |

## Verification
The bench steps through a table of flag combinations that sit inside each hysteresis band, approached from both sides. A controller that compares against only one trip point per threshold would flip the ratio there. A dwell probe tries to reverse a fresh ratio change one tick later; a missing hold-off would switch at once. The per-tick phase patterns are compared exactly for each ratio, which catches a dropped dead tick, a wrong phase length or a missing pass-through interruption. Each guard is tripped during an active phase and then held with no release. A guard without a latch would restart transfer as soon as its trip flag fell, and a late abort would leave a phase on for a clock too long.

// File: rtl/cpr_pkg.sv
`timescale 1ns/1ps
package cpr_pkg;

    typedef enum logic [1:0] {
        RATIO_NONE = 2'b00,
        RATIO_DN2  = 2'b01,
        RATIO_PASS = 2'b10,
        RATIO_UP2  = 2'b11
    } ratio_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_DRIVE_A,
        SQ_GAP_AB,
        SQ_DRIVE_B,
        SQ_GAP_BA
    } seq_e;

    localparam int TGT_W = 3;
    localparam logic [TGT_W-1:0] TGT_OFF = 3'b000;
    localparam logic [TGT_W-1:0] TGT_ADJ = 3'b001;
    localparam logic [TGT_W-1:0] TGT_5V0 = 3'b010;
    localparam logic [TGT_W-1:0] TGT_3V3 = 3'b100;

    // guard slots: 0 = overvoltage, 1 = overtemperature
    localparam int GUARD_N = 2;

endpackage

// File: rtl/cpr_trip_latch.sv
`timescale 1ns/1ps
module cpr_trip_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic trip_i,
    input  logic release_i,
    output logic held_o
);

    typedef struct packed {
        logic held;
    } latch_st_t;

    latch_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trip_i) begin
            st_d.held = 1'b1;           // trip wins over a simultaneous release
        end else if (release_i) begin
            st_d.held = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign held_o = st_q.held;

endmodule

// File: rtl/cpr_ratio_sel.sv
`timescale 1ns/1ps
module cpr_ratio_sel
    import cpr_pkg::*;
#(
    parameter int DWELL_TICKS = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tick_i,
    input  logic   seq_idle_i,
    input  logic   dbl_rise_i,
    input  logic   dbl_fall_i,
    input  logic   tgt_rise_i,
    input  logic   tgt_fall_i,
    output ratio_e ratio_o,
    output logic   pending_o
);

    localparam int DW_W = (DWELL_TICKS > 0) ? $clog2(DWELL_TICKS + 1) : 1;
    localparam logic [DW_W-1:0] DWELL_MAX = DW_W'(DWELL_TICKS);

    typedef struct packed {
        ratio_e          ratio;
        logic [DW_W-1:0] dwell;
    } ratio_st_t;

    ratio_st_t st_d, st_q;
    ratio_e    want;
    logic      above_dbl;
    logic      above_tgt;
    logic      dwell_ok;
    logic      pending;

    always_comb begin
        // each threshold uses the trip point that keeps the present ratio
        above_dbl = (st_q.ratio == RATIO_DN2) ? dbl_fall_i : dbl_rise_i;
        above_tgt = (st_q.ratio == RATIO_UP2) ? tgt_rise_i : tgt_fall_i;
        if (above_dbl) begin
            want = RATIO_DN2;
        end else if (above_tgt) begin
            want = RATIO_PASS;
        end else begin
            want = RATIO_UP2;
        end
        dwell_ok = (st_q.dwell >= DWELL_MAX);
        pending  = (want != st_q.ratio) && dwell_ok;

        st_d = st_q;
        if (tick_i) begin
            if (pending && seq_idle_i) begin
                st_d.ratio = want;
                st_d.dwell = '0;
            end else if (!dwell_ok) begin
                st_d.dwell = st_q.dwell + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ratio <= RATIO_PASS;
            st_q.dwell <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ratio_o   = st_q.ratio;
    assign pending_o = pending;

endmodule

// File: rtl/cpr_phase_seq.sv
`timescale 1ns/1ps
module cpr_phase_seq
    import cpr_pkg::*;
#(
    parameter int PHASE_TICKS  = 2,
    parameter int PERIOD_TICKS = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tick_i,
    input  logic   allow_i,
    input  logic   demand_i,
    input  logic   hold_i,
    input  ratio_e ratio_i,
    output logic   drive_a_o,
    output logic   drive_b_o,
    output logic   idle_o
);

    // pass-through: A on for all but the dead tick and the idle tick
    localparam int PASS_TICKS = PERIOD_TICKS - 2;
    localparam int MAX_LEN    = (PASS_TICKS > PHASE_TICKS) ? PASS_TICKS : PHASE_TICKS;
    localparam int CNT_W      = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
    localparam logic [CNT_W-1:0] PHASE_LAST = CNT_W'(PHASE_TICKS - 1);
    localparam logic [CNT_W-1:0] PASS_LAST  = CNT_W'(PASS_TICKS - 1);

    typedef struct packed {
        seq_e             st;
        logic [CNT_W-1:0] cnt;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic    a_done;
    logic    b_done;

    always_comb begin
        a_done = (ratio_i == RATIO_PASS) ? (st_q.cnt == PASS_LAST)
                                         : (st_q.cnt == PHASE_LAST);
        b_done = (st_q.cnt == PHASE_LAST);
        st_d   = st_q;
        if (!allow_i) begin
            st_d.st  = SQ_IDLE;
            st_d.cnt = '0;
        end else if (tick_i) begin
            case (st_q.st)
                SQ_IDLE: begin
                    if (demand_i && !hold_i) begin
                        st_d.st  = SQ_DRIVE_A;
                        st_d.cnt = '0;
                    end
                end
                SQ_DRIVE_A: begin
                    if (a_done) begin
                        st_d.cnt = '0;
                        st_d.st  = (ratio_i == RATIO_PASS) ? SQ_GAP_BA : SQ_GAP_AB;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                SQ_GAP_AB: begin
                    st_d.st  = SQ_DRIVE_B;
                    st_d.cnt = '0;
                end
                SQ_DRIVE_B: begin
                    if (b_done) begin
                        st_d.cnt = '0;
                        st_d.st  = SQ_GAP_BA;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                SQ_GAP_BA: begin
                    st_d.st  = SQ_IDLE;
                    st_d.cnt = '0;
                end
                default: begin
                    st_d.st  = SQ_IDLE;
                    st_d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.st  <= SQ_IDLE;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign drive_a_o = (st_q.st == SQ_DRIVE_A);
    assign drive_b_o = (st_q.st == SQ_DRIVE_B);
    assign idle_o    = (st_q.st == SQ_IDLE);

endmodule

// File: rtl/cp_ratio_ctrl.sv
`timescale 1ns/1ps
module cp_ratio_ctrl
    import cpr_pkg::*;
#(
    parameter int PHASE_TICKS  = 2,
    parameter int PERIOD_TICKS = 8,
    parameter int DWELL_TICKS  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel_i,
    input  logic       osc_tick_i,
    input  logic       dbl_rise_i,
    input  logic       dbl_fall_i,
    input  logic       tgt_rise_i,
    input  logic       tgt_fall_i,
    input  logic       out_low_i,
    input  logic       ovp_trip_i,
    input  logic       ovp_release_i,
    input  logic       ot_trip_i,
    input  logic       ot_release_i,
    input  logic       uvlo_i,
    output logic [2:0] target_o,
    output logic [1:0] ratio_o,
    output logic       phase_a_o,
    output logic       phase_b_o,
    output logic       pulldown_o
);

    typedef struct packed {
        logic [TGT_W-1:0] tgt;
    } top_st_t;

    top_st_t            st_d, st_q;
    logic [GUARD_N-1:0] trip_vec;
    logic [GUARD_N-1:0] rel_vec;
    logic [GUARD_N-1:0] held_vec;
    logic               allow;
    logic               seq_idle;
    logic               pending;
    ratio_e             ratio;

    assign trip_vec = {ot_trip_i, ovp_trip_i};
    assign rel_vec  = {ot_release_i, ovp_release_i};

    for (genvar g = 0; g < GUARD_N; g++) begin : g_guard
        cpr_trip_latch u_latch (
            .clk       (clk),
            .rst_n     (rst_n),
            .trip_i    (trip_vec[g]),
            .release_i (rel_vec[g]),
            .held_o    (held_vec[g])
        );
    end

    always_comb begin
        st_d = st_q;
        case (sel_i)
            2'b01:   st_d.tgt = TGT_ADJ;
            2'b10:   st_d.tgt = TGT_5V0;
            2'b11:   st_d.tgt = TGT_3V3;
            default: st_d.tgt = TGT_OFF;
        endcase
        allow = (sel_i != 2'b00) && !uvlo_i && !(|trip_vec) && !(|held_vec);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.tgt <= TGT_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    cpr_ratio_sel #(
        .DWELL_TICKS (DWELL_TICKS)
    ) u_ratio (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (osc_tick_i),
        .seq_idle_i (seq_idle),
        .dbl_rise_i (dbl_rise_i),
        .dbl_fall_i (dbl_fall_i),
        .tgt_rise_i (tgt_rise_i),
        .tgt_fall_i (tgt_fall_i),
        .ratio_o    (ratio),
        .pending_o  (pending)
    );

    cpr_phase_seq #(
        .PHASE_TICKS  (PHASE_TICKS),
        .PERIOD_TICKS (PERIOD_TICKS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (osc_tick_i),
        .allow_i   (allow),
        .demand_i  (out_low_i),
        .hold_i    (pending),
        .ratio_i   (ratio),
        .drive_a_o (phase_a_o),
        .drive_b_o (phase_b_o),
        .idle_o    (seq_idle)
    );

    assign target_o   = st_q.tgt;
    assign ratio_o    = ratio;
    assign pulldown_o = (st_q.tgt == TGT_OFF);

endmodule

// File: rtl/cp_ratio_ctrl_chk.sv
`timescale 1ns/1ps
module cp_ratio_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       osc_tick_i,
    input logic       out_low_i,
    input logic       ovp_trip_i,
    input logic       ot_trip_i,
    input logic       uvlo_i,
    input logic [1:0] ratio_o,
    input logic       phase_a_o,
    input logic       phase_b_o,
    input logic       pulldown_o
);

    AST_RATIO_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_o != 2'b00); // R2

    AST_RATIO_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ratio_o) |-> $past(osc_tick_i)); // R2

    AST_RATIO_HELD_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_a_o || phase_b_o) |-> $stable(ratio_o)); // R4

    AST_START_NEEDS_DEMAND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_a_o) |-> $past(out_low_i && osc_tick_i)); // R5

    AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(phase_a_o && phase_b_o)); // R8

    AST_DEAD_BEFORE_B: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_b_o) |-> !$past(phase_a_o)); // R8

    AST_DEAD_BEFORE_A: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_a_o) |-> !$past(phase_b_o)); // R8

    AST_OVP_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        ovp_trip_i |=> (!phase_a_o && !phase_b_o)); // R9

    AST_OT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        ot_trip_i |=> (!phase_a_o && !phase_b_o)); // R10

    AST_UVLO_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo_i |=> (!phase_a_o && !phase_b_o)); // R11

    AST_PULLDOWN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulldown_o |-> (!phase_a_o && !phase_b_o)); // R11

endmodule

bind cp_ratio_ctrl cp_ratio_ctrl_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .osc_tick_i (osc_tick_i),
    .out_low_i  (out_low_i),
    .ovp_trip_i (ovp_trip_i),
    .ot_trip_i  (ot_trip_i),
    .uvlo_i     (uvlo_i),
    .ratio_o    (ratio_o),
    .phase_a_o  (phase_a_o),
    .phase_b_o  (phase_b_o),
    .pulldown_o (pulldown_o)
);

// File: tb/test_cp_ratio_ctrl.sv
`timescale 1ns/1ps
module test_cp_ratio_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel = 2'b00;
    logic       osc_tick = 1'b0;
    logic       dr = 1'b0, df = 1'b0, tr = 1'b0, tf = 1'b0;
    logic       out_low = 1'b0;
    logic       ovp_trip = 1'b0, ovp_rel = 1'b0;
    logic       ot_trip = 1'b0, ot_rel = 1'b0;
    logic       uvlo = 1'b0;
    logic [2:0] target_o;
    logic [1:0] ratio_o;
    logic       phase_a_o, phase_b_o, pulldown_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // ratio codes: 01 step-down, 10 pass, 11 step-up
    // entry: sel[10:9] dr df tr tf [8:5] target[4:2] ratio[1:0]
    localparam logic [10:0] VEC [0:11] = '{
        11'b11_0011_100_10,
        11'b10_1111_010_01,
        11'b01_0111_001_01,
        11'b11_0011_100_10,
        11'b10_0111_010_10,
        11'b01_0001_001_10,
        11'b11_0000_100_11,
        11'b10_0001_010_11,
        11'b01_0011_001_10,
        11'b00_0000_000_11,
        11'b11_1111_100_01,
        11'b10_1111_010_01
    };

    always #2.5 clk = ~clk;

    cp_ratio_ctrl i_cp_ratio_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .sel_i         (sel),
        .osc_tick_i    (osc_tick),
        .dbl_rise_i    (dr),
        .dbl_fall_i    (df),
        .tgt_rise_i    (tr),
        .tgt_fall_i    (tf),
        .out_low_i     (out_low),
        .ovp_trip_i    (ovp_trip),
        .ovp_release_i (ovp_rel),
        .ot_trip_i     (ot_trip),
        .ot_release_i  (ot_rel),
        .uvlo_i        (uvlo),
        .target_o      (target_o),
        .ratio_o       (ratio_o),
        .phase_a_o     (phase_a_o),
        .phase_b_o     (phase_b_o),
        .pulldown_o    (pulldown_o)
    );

    task automatic check(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic tick_once();
        @(negedge clk);
        osc_tick = 1'b1;
        @(negedge clk);
        osc_tick = 1'b0;
    endtask

    task automatic count_active(input int n, output int hits);
        hits = 0;
        repeat (n) begin
            tick_once();
            if (phase_a_o || phase_b_o) hits++;
        end
    endtask

    task automatic trace(input int n, output logic [15:0] a_seen, output logic [15:0] b_seen);
        a_seen = '0;
        b_seen = '0;
        for (int k = 0; k < n; k++) begin
            tick_once();
            a_seen[k] = phase_a_o;
            b_seen[k] = phase_b_o;
        end
    endtask

    task automatic set_flags(input logic [3:0] f);
        {dr, df, tr, tf} = f;
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R12 watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] a_seen, b_seen;
        int hits;

        // R12 reset state
        repeat (4) @(negedge clk);
        check("R12 phase_a in reset", int'(phase_a_o), 0);
        check("R12 ratio in reset", int'(ratio_o), 2);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 phase_b after reset", int'(phase_b_o), 0);
        check("R12 pulldown after reset", int'(pulldown_o), 1);
        check("R12 target after reset", int'(target_o), 0);

        // table walk: decode and hysteresis, no demand
        for (int i = 0; i < 12; i++) begin
            logic [10:0] v;
            v   = VEC[i];
            sel = v[10:9];
            set_flags(v[8:5]);
            repeat (4) tick_once();
            check("R1 target decode", int'(target_o), int'(v[4:2]));
            check("R1 pulldown", int'(pulldown_o), int'(v[4:2] == 3'b000));
            check("R2/R3 ratio choice", int'(ratio_o), int'(v[1:0]));
        end

        // R4 dwell: ratio now 01, sel 10
        set_flags(4'b0000);
        tick_once();
        check("R4 change to step-up", int'(ratio_o), 3);
        set_flags(4'b1111);
        tick_once();
        check("R4 held after one tick", int'(ratio_o), 3);
        tick_once();
        check("R4 held after two ticks", int'(ratio_o), 3);
        tick_once();
        check("R4 change on third tick", int'(ratio_o), 1);

        // R6 step-down burst pattern
        out_low = 1'b1;
        trace(8, a_seen, b_seen);
        check("R6 step-down phase A", int'(a_seen[7:0]), 8'b1000_0011);
        check("R6 step-down phase B", int'(b_seen[7:0]), 8'b0001_1000);
        out_low = 1'b0;
        repeat (10) tick_once();
        count_active(8, hits);
        check("R5 no transfer without demand", hits, 0);

        // R6 step-up burst pattern
        set_flags(4'b0000);
        repeat (4) tick_once();
        check("R2 step-up code", int'(ratio_o), 3);
        out_low = 1'b1;
        trace(8, a_seen, b_seen);
        check("R6 step-up phase A", int'(a_seen[7:0]), 8'b1000_0011);
        check("R6 step-up phase B", int'(b_seen[7:0]), 8'b0001_1000);
        out_low = 1'b0;
        repeat (10) tick_once();

        // R7 pass-through pattern
        set_flags(4'b0011);
        repeat (4) tick_once();
        check("R2 pass code", int'(ratio_o), 2);
        out_low = 1'b1;
        trace(9, a_seen, b_seen);
        check("R7 pass phase A", int'(a_seen[8:0]), 9'b1_0011_1111);
        check("R7 pass phase B", int'(b_seen[8:0]), 0);

        // R9 overvoltage latch (phase A active now)
        ovp_trip = 1'b1;
        @(negedge clk);
        check("R9 abort on trip", int'(phase_a_o || phase_b_o), 0);
        ovp_trip = 1'b0;
        count_active(10, hits);
        check("R9 held until release", hits, 0);
        ovp_rel = 1'b1;
        @(negedge clk);
        ovp_rel = 1'b0;
        tick_once();
        check("R9 resume after release", int'(phase_a_o), 1);

        // R10 overtemperature latch
        ot_trip = 1'b1;
        @(negedge clk);
        check("R10 abort on trip", int'(phase_a_o || phase_b_o), 0);
        ot_trip = 1'b0;
        count_active(10, hits);
        check("R10 held until release", hits, 0);
        ot_rel = 1'b1;
        @(negedge clk);
        ot_rel = 1'b0;
        tick_once();
        check("R10 resume after release", int'(phase_a_o), 1);

        // R11 lockout, not latched
        uvlo = 1'b1;
        @(negedge clk);
        check("R11 lockout abort", int'(phase_a_o || phase_b_o), 0);
        count_active(6, hits);
        check("R11 lockout blocks", hits, 0);
        uvlo = 1'b0;
        tick_once();
        check("R11 resume after lockout", int'(phase_a_o), 1);

        // R11 shutdown
        sel = 2'b00;
        @(negedge clk);
        check("R11 shutdown abort", int'(phase_a_o || phase_b_o), 0);
        check("R11 shutdown pulldown", int'(pulldown_o), 1);
        count_active(6, hits);
        check("R11 shutdown blocks", hits, 0);
        sel = 2'b01;
        tick_once();
        check("R1 adjustable after shutdown", int'(target_o), 1);
        check("R11 restart after shutdown", int'(phase_a_o), 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule